// File: doc/BRIEF.md
# Maskable Interrupt Combiner with Release Window

This block merges four internal interrupt sources into one active-low interrupt line for a host processor. Each source has a sticky pending flag. A pulse on the source's set input sets the flag, and the flag stays set until the source's clear strobe is applied. A per-source enable mask selects which pending flags may pull the line low.

A mode bit sets what happens when one of several enabled pending sources is cleared while the line is low:
- **Level mode** (`gap_mode = 0`): the line stays low.
- **Release mode** (`gap_mode = 1`): the line goes high for a fixed window of about 50 µs and then goes low again. An edge-sensitive host therefore sees a fresh falling edge.

The window length in clock cycles is derived from the clock frequency parameter.

A three-state machine controls the line:
- **IRQ_IDLE**: the line is high. The transition *raise* goes to IRQ_ACTIVE when any enabled flag is pending.
- **IRQ_ACTIVE**: the line is low. Three transitions leave or keep this state:
  - *quiet* returns to IRQ_IDLE when no enabled flag is pending.
  - *gap_open* goes to IRQ_GAP when release mode is selected, an enabled flag was just cleared, and at least one enabled flag is still pending.
  - Otherwise the state *holds*.
- **IRQ_GAP**: the line is high while the window counter runs. Flags that arrive and clears that happen during the window have no effect on its length. When the window ends, *gap_rearm* goes to IRQ_ACTIVE if an enabled flag is pending, and *gap_idle* goes to IRQ_IDLE if none is.

Top module: `irq_combiner`

## Requirements
- R1: After reset `irq_n` is 1 and `pending` is 4'b0000.
- R2: `pending` bit order is bit 0 overflow, bit 1 key event, bit 2 logic, bit 3 general-purpose input. A `src_set[i]` pulse sets `pending[i]` one cycle later, and the bit holds until a `src_clr[i]` strobe.
- R3: When `src_set[i]` and `src_clr[i]` are both 1 in one cycle, `pending[i]` ends up set.
- R4: `irq_n` goes to 0 two cycles after a set pulse on a source whose `irq_en` bit is 1. A pending source whose `irq_en` bit is 0 does not pull `irq_n` low.
- R5: When the last enabled pending source is cleared, `irq_n` returns to 1 two cycles after the clear and no release window starts. A later enabled set pulls the line low again two cycles after that set.
- R6: With `gap_mode` = 0, clearing one of several enabled pending sources leaves `irq_n` at 0.
- R7: With `gap_mode` = 1, clearing one of several enabled pending sources drives `irq_n` to 1 two cycles after the clear. The line then stays at 1 for exactly GAP_CYCLES = (CLK_HZ/1e6)·GAP_US cycles before returning to 0.
- R8: Set pulses and clears that occur during the release window neither shorten it nor restart it.
- R9: Clearing a source whose `irq_en` bit is 0 never opens a release window.
- R10: If no enabled source is pending when the window ends, `irq_n` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 4 | Per-source set pulses |
| src_clr | input | 4 | Per-source clear strobes |
| irq_en | input | 4 | Per-source enable mask |
| gap_mode | input | 1 | 0 holds the line low, 1 opens a release window |
| pending | output | 4 | Sticky pending flags |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
Both the pending flags and the line state are registered outputs. A pending bit changes one cycle after the set or clear edge, and `irq_n` responds two cycles after the set or clear. When a release window closes, the line returns to its asserted level exactly GAP_CYCLES cycles after it rose.

The bench changes inputs on the falling clock edge. A cycle-accurate reference model, built from the requirements, advances on the rising edge. Both `irq_n` and `pending` are compared against this model on every falling edge. The directed checks wait exactly two falling edges after each stimulus before sampling, and they measure the length of each high run of the line cycle by cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_ACTIVE = 2'd1,
        IRQ_GAP    = 2'd2
    } irq_state_t;

    localparam int SRC_OVERFLOW = 0;
    localparam int SRC_KEYEVT   = 1;
    localparam int SRC_LOGIC    = 2;
    localparam int SRC_GPIN     = 3;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flag_o,
    output logic [NUM_SRC-1:0] drop_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic flag_q;
        logic drop_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                drop_q <= 1'b0;
            end else begin
                // set wins over clear
                flag_q <= set_i[g] | (flag_q & ~clr_i[g]);
                drop_q <= flag_q & clr_i[g] & ~set_i[g];
            end
        end

        assign flag_o[g] = flag_q;
        assign drop_o[g] = drop_q;

        assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]);
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !clr_i[g]) |=> $stable(flag_o[g]));
    end
endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
    parameter int GAP_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (run_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LAST);

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0));
    assert_counts_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] drop_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gap_mode_i,
    input  logic               gap_done_i,
    output logic               gap_start_o,
    output logic               gap_run_o,
    output logic               irq_n_o
);
    irq_state_t state_q, state_d;
    logic       any_live;
    logic       live_drop;

    assign any_live  = |(flag_i & en_i);
    assign live_drop = |(drop_i & en_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (any_live) state_d = IRQ_ACTIVE;                 // raise
            end
            IRQ_ACTIVE: begin
                if (!any_live)                     state_d = IRQ_IDLE; // quiet
                else if (gap_mode_i && live_drop)  state_d = IRQ_GAP;  // gap_open
            end
            IRQ_GAP: begin
                if (gap_done_i) state_d = any_live ? IRQ_ACTIVE : IRQ_IDLE; // gap_rearm / gap_idle
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n_o     = (state_q != IRQ_ACTIVE);
        gap_run_o   = (state_q == IRQ_GAP);
        gap_start_o = (state_q != IRQ_GAP) && (state_d == IRQ_GAP);
    end

    assert_gap_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ACTIVE && gap_mode_i && live_drop && any_live) |=> (state_q == IRQ_GAP));
    assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ACTIVE && !gap_mode_i && any_live) |=> (state_q == IRQ_ACTIVE));
    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ACTIVE && !any_live) |=> (state_q == IRQ_IDLE));
    assert_gap_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_GAP && !gap_done_i) |=> (state_q == IRQ_GAP));
    assert_gap_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_GAP && gap_done_i && !any_live) |=> (state_q == IRQ_IDLE));
    assert_masked_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_IDLE && !any_live) |=> (state_q == IRQ_IDLE));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
    parameter int NUM_SRC = 4,
    parameter int CLK_HZ  = 250_000_000,
    parameter int GAP_US  = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               gap_mode,
    output logic [NUM_SRC-1:0] pending,
    output logic               irq_n
);
    localparam int GAP_CYCLES = (CLK_HZ / 1_000_000) * GAP_US;

    logic [NUM_SRC-1:0] drop;
    logic               gap_start;
    logic               gap_run;
    logic               gap_done;

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (src_clr),
        .flag_o (pending),
        .drop_o (drop)
    );

    irq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (gap_start),
        .run_i   (gap_run),
        .done_o  (gap_done)
    );

    irq_line_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_i      (pending),
        .drop_i      (drop),
        .en_i        (irq_en),
        .gap_mode_i  (gap_mode),
        .gap_done_i  (gap_done),
        .gap_start_o (gap_start),
        .gap_run_o   (gap_run),
        .irq_n_o     (irq_n)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_n && pending == '0));
    assert_low_needs_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n) |-> |(pending & irq_en) || $past(|(pending & irq_en)));
endmodule

// File: tb/test_irq_combiner.sv
module test_irq_combiner;
    localparam int CLK_HZ = 1_000_000;   // shortened window for simulation
    localparam int GAP_US = 50;
    localparam int W      = (CLK_HZ / 1_000_000) * GAP_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_set = '0, src_clr = '0, irq_en = 4'hF;
    logic       gap_mode = 1'b0;
    logic [3:0] pending;
    logic       irq_n;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    irq_combiner #(.NUM_SRC(4), .CLK_HZ(CLK_HZ), .GAP_US(GAP_US)) i_irq_combiner (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .irq_en(irq_en), .gap_mode(gap_mode), .pending(pending), .irq_n(irq_n)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model
    int         m_st = 0, m_cnt = 0;
    logic [3:0] m_flag = '0, m_drop = '0;

    function automatic logic [3:0] next_flag(logic [3:0] f, logic [3:0] s, logic [3:0] c);
        return s | (f & ~c);
    endfunction

    function automatic logic exp_irq_n(int st);
        return (st != 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_flag = '0; m_drop = '0;
        end else begin
            logic act, den;
            act = |(m_flag & irq_en);
            den = |(m_drop & irq_en);
            case (m_st)
                0: if (act) m_st = 1;
                1: if (!act) m_st = 0;
                   else if (gap_mode && den) begin m_st = 2; m_cnt = 0; end
                default: if (m_cnt == W - 1) m_st = act ? 1 : 0;
                         else m_cnt++;
            endcase
            m_drop = m_flag & src_clr & ~src_set;
            m_flag = next_flag(m_flag, src_set, src_clr);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(irq_n === exp_irq_n(m_st), (m_st == 2) ? "R7 line" : "R4 line",
                32'(irq_n), 32'(exp_irq_n(m_st)));
            chk(pending === m_flag, "R2 pending", 32'(pending), 32'(m_flag));
        end
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [3:0] s, logic [3:0] c);
        src_set = s; src_clr = c;
        tick(1);
        src_set = '0; src_clr = '0;
    endtask

    task automatic high_run(output int len);
        len = 0;
        while (irq_n === 1'b1 && len < 4 * W) begin len++; tick(1); end
    endtask

    initial begin
        int len;
        void'($urandom(32'h5EED_1234));
        tick(3);
        chk(irq_n === 1'b1 && pending === 4'h0, "R1 reset", {pending, 3'b0, irq_n}, 32'h1);
        rst_n = 1'b1;
        tick(2);

        // R2/R4: overflow source (bit 0) raises the line two cycles later
        pulse(4'b0001, 4'b0000);
        chk(pending[0] === 1'b1, "R2 set visible", 32'(pending), 32'h1);
        chk(irq_n === 1'b1, "R4 not yet", 32'(irq_n), 32'h1);
        tick(1);
        chk(irq_n === 1'b0, "R4 asserted", 32'(irq_n), 32'h0);

        // R3: set and clear together on bit 1
        pulse(4'b0010, 4'b0010);
        chk(pending[1] === 1'b1, "R3 set wins", 32'(pending), 32'h3);

        // R6: level mode, clear bit 0 while bit 1 pending
        pulse(4'b0000, 4'b0001);
        for (int i = 0; i < 4; i++) begin
            chk(irq_n === 1'b0, "R6 line held", 32'(irq_n), 32'h0);
            tick(1);
        end

        // R9: release mode, clear of a disabled source (bit 3)
        gap_mode = 1'b1;
        irq_en = 4'b0110;
        pulse(4'b1000, 4'b0000);
        tick(2);
        pulse(4'b0000, 4'b1000);
        for (int i = 0; i < 5; i++) begin
            chk(irq_n === 1'b0, "R9 masked clear", 32'(irq_n), 32'h0);
            tick(1);
        end
        irq_en = 4'hF;

        // R7/R8: bits 1,2 pending; clear bit 1; disturb the window
        pulse(4'b0100, 4'b0000);
        tick(2);
        pulse(4'b0000, 4'b0010);
        tick(1);
        chk(irq_n === 1'b1, "R7 released", 32'(irq_n), 32'h1);
        tick(3);
        pulse(4'b0001, 4'b0100);
        tick(2);
        high_run(len);
        chk(len + 6 == W, "R8 window length", 32'(len + 6), 32'(W));
        chk(irq_n === 1'b0, "R7 reasserted", 32'(irq_n), 32'h0);

        // R10: window ends with nothing enabled pending
        pulse(4'b1000, 4'b0000);
        tick(2);
        pulse(4'b0000, 4'b1000);
        tick(3);
        pulse(4'b0000, 4'b0001);
        tick(W + 4);
        chk(irq_n === 1'b1, "R10 stays released", 32'(irq_n), 32'h1);

        // R5: last enabled source cleared, no window
        pulse(4'b0100, 4'b0000);
        tick(2);
        chk(irq_n === 1'b0, "R5 setup", 32'(irq_n), 32'h0);
        pulse(4'b0000, 4'b0100);
        tick(1);
        chk(irq_n === 1'b1, "R5 released", 32'(irq_n), 32'h1);
        pulse(4'b0010, 4'b0000);
        tick(1);
        chk(irq_n === 1'b0, "R5 no window", 32'(irq_n), 32'h0);

        // constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] s, c;
            for (int b = 0; b < 4; b++) begin
                s[b] = ($urandom % 16) == 0;
                c[b] = ($urandom % 12) == 0;
            end
            src_set = s; src_clr = c;
            if (($urandom % 200) == 0) irq_en = 4'($urandom);
            if (($urandom % 300) == 0) gap_mode = ~gap_mode;
            tick(1);
        end
        src_set = '0; src_clr = '0;
        tick(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule